// File: doc/BRIEF.md
# Extended-Address Port Pin Controller

This block controls a port of eight pins. Each pin can work on its own as a general-purpose I/O line or as one bit of the page part of an extended memory address. A small register interface sets three configuration registers and reads back the pin levels. Those registers are a per-pin role mask, a per-pin drive-style mask and an output data byte. The bus side supplies the address page of the current access, a flag that marks the access as extended, and the hold, idle, powerdown and standby state flags. The pad side receives three per-pin signals: a level, an enable and an open-drain marker.

The register requests use a valid/ready handshake. `req_ready` is high whenever reset is released, so a request is taken in any cycle where `req_valid` is high out of reset. A read returns its data through `rsp_valid`/`rsp_data` exactly one cycle later. The response has no ready input, so the requester must take the response in the cycle it appears.

While an access is nonextended, the output data byte is the page value on address-role pins. A build option instead holds that page at zero. With the option set, writing the data byte cannot move the page.

Top module: `ep_port_ctl`

## Requirements
- R1: After reset the role mask reads 0x00, the drive-style mask reads 0xFF and the data byte reads 0xFF. Every pin has `pin_oe`=0 and `pin_od`=1.
- R2: Role bit 0 gives an I/O pin. Its level comes from the data bit, and the extended-access flag and address bits have no effect on it until the role bit is written again.
- R3: An I/O pin with drive-style bit 0 is push-pull: `pin_oe`=1, `pin_od`=0, and `pin_out` is the data bit.
- R4: An I/O pin with drive-style bit 1 is open-drain: `pin_od`=1, and `pin_oe` is high only when its level is 0. An open-drain pin never drives a 1.
- R5: Role bit 1 gives an address pin. Outside the quiet states it is push-pull (`pin_oe`=1, `pin_od`=0) whatever its drive-style bit says.
- R6: While reset, hold, idle, powerdown or standby is active, an address pin follows its drive-style bit as in R3/R4. The level it uses is still its address value.
- R7: During an extended access (`xaccess`=1) an address pin outputs its bit of `xaddr`.
- R8: During a nonextended access an address pin outputs its data bit. With FORCE_PAGE0=1 it outputs 0 instead.
- R9: Offset 7 reads the pin levels after a two-flop synchronizer, whatever the configuration. Writes to offset 7 change nothing.
- R10: A data byte write shows on I/O pins in the cycle right after the write is accepted.
- R11: A read accepted in cycle t gives `rsp_valid` in cycle t+1 and at no other time. Offsets 1, 3 and 5 return the role mask, the drive-style mask and the data byte. Unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; also a quiet state |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (high out of reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset (1 role, 3 drive style, 5 data, 7 pin levels) |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_data | output | W | Read data |
| xaccess | input | 1 | Current access is extended |
| xaddr | input | W | Extended address page bits |
| hold_i | input | 1 | Bus released to another master |
| idle_i | input | 1 | Idle state |
| pdown_i | input | 1 | Powerdown state |
| stby_i | input | 1 | Standby state |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Per-pin output level |
| pin_oe | output | W | Per-pin output enable |
| pin_od | output | W | Per-pin open-drain marker |

## Verification
The assertions check on every cycle the properties that hold at all times. The read response comes exactly one cycle after an accepted read and never otherwise. Address pins outside the quiet states are always push-pull and carry `xaddr` during extended accesses. An open-drain pin never drives high, a drive-style bit of 0 never yields open-drain, and with the zero-page option address pins stay low on nonextended accesses. Only the bench scenarios can show the rest: the reset values, the register readback through the handshake, each quiet flag on its own handing address pins back to the drive-style bit, the synchronizer delay on pin readback, and that writes to the readback offset are ignored.

// File: rtl/ep_pkg.sv
`timescale 1ns/1ps
package ep_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] OFF_ROLE  = 3'd1;
  localparam logic [AW-1:0] OFF_STYLE = 3'd3;
  localparam logic [AW-1:0] OFF_DATA  = 3'd5;
  localparam logic [AW-1:0] OFF_LEVEL = 3'd7;
endpackage

// File: rtl/ep_sync.sv
`timescale 1ns/1ps
module ep_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '0;
        else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ep_regs.sv
`timescale 1ns/1ps
module ep_regs
  import ep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  level,
  output logic [W-1:0]  role_q,
  output logic [W-1:0]  style_q,
  output logic [W-1:0]  data_q,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_data
);
  logic [W-1:0] rd_mux;

  always_comb begin
    case (addr)
      OFF_ROLE:  rd_mux = role_q;
      OFF_STYLE: rd_mux = style_q;
      OFF_DATA:  rd_mux = data_q;
      OFF_LEVEL: rd_mux = level;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q    <= '0;
      style_q   <= '1;
      data_q    <= '1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
      if (wr_en) begin
        case (addr)
          OFF_ROLE:  role_q  <= wdata;
          OFF_STYLE: style_q <= wdata;
          OFF_DATA:  data_q  <= wdata;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ep_pinmux.sv
`timescale 1ns/1ps
module ep_pinmux #(
  parameter int W           = 8,
  parameter bit FORCE_PAGE0 = 1'b0
) (
  input  logic [W-1:0] role,
  input  logic [W-1:0] style,
  input  logic [W-1:0] data,
  input  logic         xaccess,
  input  logic [W-1:0] xaddr,
  input  logic         quiet,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_od
);
  logic [W-1:0] page;
  logic [W-1:0] addr_val;

  if (FORCE_PAGE0) begin : g_zero_page
    assign page = '0;
  end else begin : g_data_page
    assign page = data;
  end

  assign addr_val = xaccess ? xaddr : page;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl, force_pp, odrain;
    assign lvl      = role[i] ? addr_val[i] : data[i];
    assign force_pp = role[i] & ~quiet;
    assign odrain   = ~force_pp & style[i];
    assign pin_out[i] = lvl;
    assign pin_od[i]  = odrain;
    assign pin_oe[i]  = odrain ? ~lvl : 1'b1;
  end
endmodule

// File: rtl/ep_port_ctl.sv
`timescale 1ns/1ps
module ep_port_ctl
  import ep_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit FORCE_PAGE0 = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_data,
  input  logic          xaccess,
  input  logic [W-1:0]  xaddr,
  input  logic          hold_i,
  input  logic          idle_i,
  input  logic          pdown_i,
  input  logic          stby_i,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_od
);
  logic [W-1:0] role_q, style_q, data_q, level_s;
  logic         take, quiet;

  assign req_ready = rst_n;
  assign take      = req_valid & req_ready;
  assign quiet     = ~rst_n | hold_i | idle_i | pdown_i | stby_i;

  ep_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level_s)
  );

  ep_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(take & req_write), .rd_en(take & ~req_write),
    .addr(req_addr), .wdata(req_wdata), .level(level_s),
    .role_q(role_q), .style_q(style_q), .data_q(data_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  ep_pinmux #(.W(W), .FORCE_PAGE0(FORCE_PAGE0)) u_mux (
    .role(role_q), .style(style_q), .data(data_q),
    .xaccess(xaccess), .xaddr(xaddr), .quiet(quiet),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od)
  );
endmodule

// File: rtl/ep_port_chk.sv
`timescale 1ns/1ps
module ep_port_chk #(
  parameter int W           = 8,
  parameter bit FORCE_PAGE0 = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic         rsp_valid,
  input logic         xaccess,
  input logic [W-1:0] xaddr,
  input logic         hold_i,
  input logic         idle_i,
  input logic         pdown_i,
  input logic         stby_i,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_od,
  input logic [W-1:0] role_q,
  input logic [W-1:0] style_q
);
  logic calm;
  assign calm = ~(hold_i | idle_i | pdown_i | stby_i);

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R11
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R11
  AST_ADDR_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    calm |-> (((pin_oe & role_q) == role_q) && ((pin_od & role_q) == '0))); // R5
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_od & pin_oe & pin_out) == '0)); // R4
  AST_STYLE0_NOT_OD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_od & ~style_q) == '0)); // R3
  AST_EXT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (calm && xaccess) |-> (((pin_out ^ xaddr) & role_q) == '0)); // R7

  if (FORCE_PAGE0) begin : g_p0
    AST_ZERO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      !xaccess |-> ((pin_out & role_q) == '0)); // R8
  end
endmodule

bind ep_port_ctl ep_port_chk #(.W(W), .FORCE_PAGE0(FORCE_PAGE0)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .xaccess(xaccess),
  .xaddr(xaddr), .hold_i(hold_i), .idle_i(idle_i), .pdown_i(pdown_i),
  .stby_i(stby_i), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
  .role_q(role_q), .style_q(style_q)
);

// File: tb/sim_ep_port_ctl.sv
`timescale 1ns/1ps
module sim_ep_port_ctl;
  localparam int W = 8;
  localparam realtime TCK = 4.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic xaccess = 1'b0;
  logic [W-1:0] xaddr = '0, pin_in = '0;
  logic hold_i = 1'b0, idle_i = 1'b0, pdown_i = 1'b0, stby_i = 1'b0;

  logic rdy0, rv0, rdy1, rv1;
  logic [W-1:0] rd0, rd1, o0, oe0, od0, o1, oe1, od1;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  bit finished = 1'b0;

  always #(TCK/2) clk = ~clk;

  ep_port_ctl #(.W(W), .FORCE_PAGE0(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv0), .rsp_data(rd0), .xaccess(xaccess), .xaddr(xaddr),
    .hold_i(hold_i), .idle_i(idle_i), .pdown_i(pdown_i), .stby_i(stby_i),
    .pin_in(pin_in), .pin_out(o0), .pin_oe(oe0), .pin_od(od0));

  ep_port_ctl #(.W(W), .FORCE_PAGE0(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv1), .rsp_data(rd1), .xaccess(xaccess), .xaddr(xaddr),
    .hold_i(hold_i), .idle_i(idle_i), .pdown_i(pdown_i), .stby_i(stby_i),
    .pin_in(pin_in), .pin_out(o1), .pin_oe(oe1), .pin_od(od1));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(string req, logic [W-1:0] o, logic [W-1:0] oe,
                          logic [W-1:0] od);
    chk({req, " pin_out"}, o0, o);
    chk({req, " pin_oe"}, oe0, oe);
    chk({req, " pin_od"}, od0, od);
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [W-1:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per response seen on the read channel.
  always @(negedge clk) begin
    if (rst_n && rv0) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 stray response actual=%h expected=none", rd0);
      end else begin
        chk(tag_q.pop_front(), rd0, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(TCK * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(TCK * 3);
    chk_pins("R1 in reset", 8'hFF, 8'h00, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready out of reset", {7'd0, rdy0}, 8'h01);
    chk_pins("R1 after reset", 8'hFF, 8'h00, 8'hFF);
    rd("R1 role reset", 3'd1, 8'h00);
    rd("R1 style reset", 3'd3, 8'hFF);
    rd("R1 data reset", 3'd5, 8'hFF);
    rd("R11 unused offset", 3'd0, 8'h00);

    wr(3'd3, 8'h00);
    wr(3'd5, 8'hA5);
    chk_pins("R10 R3 push-pull data", 8'hA5, 8'hFF, 8'h00);
    wr(3'd3, 8'hF0);
    chk_pins("R4 open-drain upper nibble", 8'hA5, 8'h5F, 8'hF0);
    wr(3'd3, 8'hFF);
    chk_pins("R4 all open-drain", 8'hA5, 8'h5A, 8'hFF);

    wr(3'd1, 8'h0F);
    chk_pins("R5 R8 address pins forced", 8'hA5, 8'h5F, 8'hF0);
    chk("R8 zero page variant", o1, 8'hA0);
    xaddr = 8'h3C; xaccess = 1'b1;
    #1;
    chk_pins("R7 extended access", 8'hAC, 8'h5F, 8'hF0);
    chk("R7 variant extended", o1, 8'hAC);

    hold_i = 1'b1; #1; chk_pins("R6 hold", 8'hAC, 8'h53, 8'hFF); hold_i = 1'b0;
    idle_i = 1'b1; #1; chk_pins("R6 idle", 8'hAC, 8'h53, 8'hFF); idle_i = 1'b0;
    pdown_i = 1'b1; #1; chk_pins("R6 powerdown", 8'hAC, 8'h53, 8'hFF); pdown_i = 1'b0;
    stby_i = 1'b1; #1; chk_pins("R6 standby", 8'hAC, 8'h53, 8'hFF); stby_i = 1'b0;
    #1;
    chk_pins("R5 quiet released", 8'hAC, 8'h5F, 8'hF0);

    rd("R11 role readback", 3'd1, 8'h0F);
    rd("R11 style readback", 3'd3, 8'hFF);
    rd("R11 data readback", 3'd5, 8'hA5);

    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    rd("R9 pin level", 3'd7, 8'h5A);
    wr(3'd7, 8'h00);
    chk_pins("R9 level write ignored", 8'hAC, 8'h5F, 8'hF0);
    rd("R9 level after write", 3'd7, 8'h5A);
    rd("R9 data untouched", 3'd5, 8'hA5);
    pin_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd("R9 new level", 3'd7, 8'hC3);

    wr(3'd1, 8'h00);
    chk_pins("R2 back to I/O", 8'hA5, 8'h5A, 8'hFF);
    xaddr = 8'h00; #1;
    chk_pins("R2 address ignored", 8'hA5, 8'h5A, 8'hFF);

    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule